// File: doc/BRIEF.md
# Motion Sensor Boot Sequencer

This block takes an optical motion sensor from power-on to its operating state without software involvement. After a start pulse it walks a fixed script of register accesses: a reset write, a set of throw-away reads that flush stale motion data, the writes that prepare the sensor for a firmware download, and a single long chip-select burst that carries the firmware image. It ends with a read-modify-write that switches the light source on. Between steps it inserts the waits the sensor needs. Each wait is a cycle count set by a parameter, so the block can be retargeted to any clock frequency.

Every access goes out through one request port and is carried out by a serial-link engine elsewhere in the chip. The request port uses a valid/ready pair to hand the request over and a one-cycle done pulse, with read data, to complete it. Only one access is outstanding at a time. Firmware bytes come from a separate valid/ready byte stream. The sequencer takes a byte only when it is ready to send one, and it waits for as long as the stream is stalled. When the final write completes, `init_done` rises and stays high until the next start.

Top module: `sensor_boot_seq`

## Requirements
- R1: After reset, and until `start` is seen, `acc_valid`, `fw_ready` and `init_done` are all low.
- R2: The first request is a write (op 0) with address byte 0xBA and data 0x5A. A write's address byte is the 7-bit register number with bit 7 set. The next request follows exactly RESET_CYC cycles after the done of this write. A gap is counted from the edge that samples `acc_done` to the edge that raises the next `acc_valid` or `fw_ready`. A step without a wait has a gap of 0.
- R3: Five reads (op 1) follow, to registers 0x02, 0x03, 0x04, 0x05 and 0x06 in that order. Each carries bit 7 clear and data 0x00, and the values returned are not used.
- R4: Three writes follow, in this order: 0xB9/0x02, then 0x93/0x1D, then 0x93/0x18. A wait of FRAME_CYC cycles comes after the 0x1D write.
- R5: A burst-open request (op 2) with address byte 0xE2 opens the firmware burst. A wait of GAP_CYC cycles follows it.
- R6: FW_LEN burst-byte requests (op 3) follow, with the stream bytes as data in arrival order. Each is followed by a wait of GAP_CYC cycles. One burst-close request (op 4, address and data 0x00) then ends the burst and is followed by POST_CYC cycles.
- R7: `fw_ready` is high only while the sequencer waits for a firmware byte, and never together with `acc_valid`. While the stream holds `fw_valid` low, no request is made.
- R8: After the burst, register 0x20 is read (address byte 0x20). It is then written (address byte 0xA0) with the returned value ANDed with 0xF0.
- R9: `init_done` rises in the cycle after the done of the final write. It then holds high, with no requests, until `start`.
- R10: `start` is ignored while a sequence runs. A `start` while idle or finished clears `init_done` and begins the script again at R2.
- R11: A request that is not accepted stays valid with op, address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) the boot script |
| acc_valid | output | 1 | Register-access request valid |
| acc_op | output | 3 | 0 write, 1 read, 2 burst open, 3 burst byte, 4 burst close |
| acc_addr | output | 8 | First byte on the link (bit 7 set for writes and burst open) |
| acc_data | output | 8 | Write data or firmware byte |
| acc_ready | input | 1 | Request accepted |
| acc_done | input | 1 | One-cycle pulse: access finished |
| acc_rdata | input | 8 | Read data, valid with `acc_done` |
| fw_valid | input | 1 | Firmware byte valid |
| fw_data | input | 8 | Firmware byte |
| fw_ready | output | 1 | Sequencer takes a firmware byte |
| init_done | output | 1 | Sensor booted |

## Verification
Each request output is a register. A request therefore appears in the cycle after the edge that loads it, and the bench samples it at the falling edge after that. The gap from a sampled done pulse to the next `acc_valid` or `fw_ready` is due after exactly the programmed wait count, 0 for steps without a wait. The bench records the cycle count at the falling edge where it raises `acc_done` and compares the distance to the next event against that figure. The bench samples `init_done` at the first falling edge after the final done, and the cleared flag at the first falling edge after a restart pulse.

// File: rtl/sensor_boot_pkg.sv
package sensor_boot_pkg;

  localparam int unsigned STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_FW_BYTE  = 4'd10;
  localparam logic [STEP_W-1:0] STEP_LAST     = 4'd13;
  localparam logic [7:0]        LIGHT_KEEP    = 8'hF0;

  typedef enum logic [2:0] {
    OP_WRITE  = 3'd0,
    OP_READ   = 3'd1,
    OP_BOPEN  = 3'd2,
    OP_BBYTE  = 3'd3,
    OP_BCLOSE = 3'd4
  } acc_op_e;

  typedef enum logic [2:0] {
    DLY_NONE  = 3'd0,
    DLY_RESET = 3'd1,
    DLY_FRAME = 3'd2,
    DLY_GAP   = 3'd3,
    DLY_POST  = 3'd4
  } dly_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DELAY, ST_FWWAIT, ST_DONE
  } state_e;

  typedef struct packed {
    acc_op_e    op;
    logic [6:0] reg_num;
    logic [7:0] value;
    dly_e       dly;
  } step_t;

  // Boot script: one entry per step, the firmware byte step repeats.
  function automatic step_t script_at(input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{OP_READ, 7'h00, 8'h00, DLY_NONE};
    case (idx)
      4'd0:  s = '{OP_WRITE,  7'h3A, 8'h5A, DLY_RESET};
      4'd1:  s = '{OP_READ,   7'h02, 8'h00, DLY_NONE};
      4'd2:  s = '{OP_READ,   7'h03, 8'h00, DLY_NONE};
      4'd3:  s = '{OP_READ,   7'h04, 8'h00, DLY_NONE};
      4'd4:  s = '{OP_READ,   7'h05, 8'h00, DLY_NONE};
      4'd5:  s = '{OP_READ,   7'h06, 8'h00, DLY_NONE};
      4'd6:  s = '{OP_WRITE,  7'h39, 8'h02, DLY_NONE};
      4'd7:  s = '{OP_WRITE,  7'h13, 8'h1D, DLY_FRAME};
      4'd8:  s = '{OP_WRITE,  7'h13, 8'h18, DLY_NONE};
      4'd9:  s = '{OP_BOPEN,  7'h62, 8'h00, DLY_GAP};
      4'd10: s = '{OP_BBYTE,  7'h00, 8'h00, DLY_GAP};
      4'd11: s = '{OP_BCLOSE, 7'h00, 8'h00, DLY_POST};
      4'd12: s = '{OP_READ,   7'h20, 8'h00, DLY_NONE};
      4'd13: s = '{OP_WRITE,  7'h20, 8'h00, DLY_NONE};
      default: s = '{OP_READ, 7'h00, 8'h00, DLY_NONE};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sensor_boot_script.sv
module sensor_boot_script
  import sensor_boot_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [7:0]        fw_byte_i,
  input  logic [7:0]        rmw_src_i,
  output acc_op_e           op_o,
  output logic [7:0]        wire_addr_o,
  output logic [7:0]        data_o,
  output dly_e              dly_o
);

  step_t cur;

  always_comb begin
    cur         = script_at(step_i);
    op_o        = cur.op;
    dly_o       = cur.dly;
    wire_addr_o = {(cur.op == OP_WRITE) || (cur.op == OP_BOPEN), cur.reg_num};
    if (cur.op == OP_BBYTE) begin
      data_o = fw_byte_i;
    end else if (step_i == STEP_LAST) begin
      data_o = rmw_src_i & LIGHT_KEEP;
    end else begin
      data_o = cur.value;
    end
  end

endmodule

// File: rtl/sensor_boot_timer.sv
module sensor_boot_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sensor_boot_seq.sv
module sensor_boot_seq
  import sensor_boot_pkg::*;
#(
  parameter int unsigned FW_LEN    = 3070,
  parameter int unsigned RESET_CYC = 2500000,
  parameter int unsigned FRAME_CYC = 500000,
  parameter int unsigned GAP_CYC   = 750,
  parameter int unsigned POST_CYC  = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       acc_valid,
  output logic [2:0] acc_op,
  output logic [7:0] acc_addr,
  output logic [7:0] acc_data,
  input  logic       acc_ready,
  input  logic       acc_done,
  input  logic [7:0] acc_rdata,
  input  logic       fw_valid,
  input  logic [7:0] fw_data,
  output logic       fw_ready,
  output logic       init_done
);

  // All waits and FW_LEN must be at least 1.
  localparam int unsigned MAX_A   = (RESET_CYC > FRAME_CYC) ? RESET_CYC : FRAME_CYC;
  localparam int unsigned MAX_B   = (GAP_CYC > POST_CYC) ? GAP_CYC : POST_CYC;
  localparam int unsigned DLY_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);
  localparam int unsigned FWC_W   = (FW_LEN > 1) ? $clog2(FW_LEN) : 1;
  localparam logic [FWC_W-1:0] FW_LAST = FWC_W'(FW_LEN - 1);

  state_e            state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] adv_step;
  logic [STEP_W-1:0] load_step;
  logic [FWC_W-1:0]  fw_cnt;
  dly_e              dly_q;
  acc_op_e           acc_op_q;

  acc_op_e           rom_op;
  logic [7:0]        rom_addr;
  logic [7:0]        rom_data;
  dly_e              rom_dly;

  logic              start_ok;
  logic              fw_take;
  logic              advance;
  logic              load_en;
  logic              tmr_load;
  logic              tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  always_comb begin
    adv_step  = (step == STEP_FW_BYTE && fw_cnt != FW_LAST) ? step : step + 1'b1;
    start_ok  = (state == ST_IDLE || state == ST_DONE) && start;
    fw_take   = (state == ST_FWWAIT) && fw_valid;
    tmr_load  = (state == ST_WAIT) && acc_done && (dly_q != DLY_NONE);
    advance   = ((state == ST_WAIT) && acc_done && (dly_q == DLY_NONE)) ||
                ((state == ST_DELAY) && tmr_zero);
    load_step = start_ok ? '0 : (fw_take ? STEP_FW_BYTE : adv_step);
    load_en   = start_ok || fw_take ||
                (advance && step != STEP_LAST && adv_step != STEP_FW_BYTE);
    case (dly_q)
      DLY_RESET: tmr_val = CNT_W'(RESET_CYC - 1);
      DLY_FRAME: tmr_val = CNT_W'(FRAME_CYC - 1);
      DLY_GAP:   tmr_val = CNT_W'(GAP_CYC - 1);
      DLY_POST:  tmr_val = CNT_W'(POST_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  // The read-modify-write source is the live read data: the final write is
  // loaded on the very edge that samples the done of the light-control read.
  sensor_boot_script u_script (
    .step_i      (load_step),
    .fw_byte_i   (fw_data),
    .rmw_src_i   (acc_rdata),
    .op_o        (rom_op),
    .wire_addr_o (rom_addr),
    .data_o      (rom_data),
    .dly_o       (rom_dly)
  );

  sensor_boot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      fw_cnt    <= '0;
      init_done <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            step      <= '0;
            fw_cnt    <= '0;
            init_done <= 1'b0;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE:  if (acc_ready) state <= ST_WAIT;
        ST_WAIT:   if (tmr_load)  state <= ST_DELAY;
        ST_FWWAIT: if (fw_valid)  state <= ST_ISSUE;
        default: ;
      endcase
      if (advance) begin
        if (step == STEP_LAST) begin
          state     <= ST_DONE;
          init_done <= 1'b1;
        end else begin
          if (step == STEP_FW_BYTE) fw_cnt <= fw_cnt + 1'b1;
          step  <= adv_step;
          state <= (adv_step == STEP_FW_BYTE) ? ST_FWWAIT : ST_ISSUE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_op_q  <= OP_WRITE;
      acc_addr  <= '0;
      acc_data  <= '0;
      dly_q     <= DLY_NONE;
    end else if (load_en) begin
      acc_valid <= 1'b1;
      acc_op_q  <= rom_op;
      acc_addr  <= rom_addr;
      acc_data  <= rom_data;
      dly_q     <= rom_dly;
    end else if (state == ST_ISSUE && acc_ready) begin
      acc_valid <= 1'b0;
    end
  end

  assign acc_op   = acc_op_q;
  assign fw_ready = (state == ST_FWWAIT);

endmodule

// File: rtl/sensor_boot_chk.sv
module sensor_boot_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       acc_valid,
  input logic [2:0] acc_op,
  input logic [7:0] acc_addr,
  input logic [7:0] acc_data,
  input logic       acc_ready,
  input logic       fw_valid,
  input logic       fw_ready,
  input logic       init_done
);

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_op) && $stable(acc_addr) && $stable(acc_data)); // R11

  AST_NO_REQ_WITH_FW_READY: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> !fw_ready); // R7

  AST_BYTE_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_valid) && acc_op == 3'd3 |-> $past(fw_valid && fw_ready)); // R7

  AST_WRITE_ADDR_MSB: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_op == 3'd0 |-> acc_addr[7]); // R2

  AST_READ_ADDR_MSB: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_op == 3'd1 |-> !acc_addr[7] && acc_data == 8'h00); // R3

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_done |-> !acc_valid && !fw_ready); // R9

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
    init_done && !start |=> init_done); // R9

endmodule

bind sensor_boot_seq sensor_boot_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .acc_valid (acc_valid),
  .acc_op    (acc_op),
  .acc_addr  (acc_addr),
  .acc_data  (acc_data),
  .acc_ready (acc_ready),
  .fw_valid  (fw_valid),
  .fw_ready  (fw_ready),
  .init_done (init_done)
);

// File: tb/sensor_boot_seq_bench.sv
module sensor_boot_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FW_N     = 4;
  localparam int RST_W    = 20;
  localparam int FRM_W    = 12;
  localparam int GAP_W    = 3;
  localparam int PST_W    = 9;
  localparam int LAT      = 2;
  localparam int STALL    = 15;
  localparam int WATCHDOG = 20000;
  localparam int N_ENT    = 17;

  // Expected script: op[26:24] addr[23:16] data[15:8] gap[7:0]
  localparam logic [26:0] SCRIPT [N_ENT] = '{
    {3'd0, 8'hBA, 8'h5A, 8'(RST_W)},
    {3'd1, 8'h02, 8'h00, 8'd0},
    {3'd1, 8'h03, 8'h00, 8'd0},
    {3'd1, 8'h04, 8'h00, 8'd0},
    {3'd1, 8'h05, 8'h00, 8'd0},
    {3'd1, 8'h06, 8'h00, 8'd0},
    {3'd0, 8'hB9, 8'h02, 8'd0},
    {3'd0, 8'h93, 8'h1D, 8'(FRM_W)},
    {3'd0, 8'h93, 8'h18, 8'd0},
    {3'd2, 8'hE2, 8'h00, 8'(GAP_W)},
    {3'd3, 8'h00, 8'h00, 8'(GAP_W)},
    {3'd3, 8'h00, 8'h00, 8'(GAP_W)},
    {3'd3, 8'h00, 8'h00, 8'(GAP_W)},
    {3'd3, 8'h00, 8'h00, 8'(GAP_W)},
    {3'd4, 8'h00, 8'h00, 8'(PST_W)},
    {3'd1, 8'h20, 8'h00, 8'd0},
    {3'd0, 8'hA0, 8'h00, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       acc_valid;
  logic [2:0] acc_op;
  logic [7:0] acc_addr;
  logic [7:0] acc_data;
  logic       acc_ready = 1'b0;
  logic       acc_done = 1'b0;
  logic [7:0] acc_rdata = 8'h00;
  logic       fw_valid = 1'b0;
  logic [7:0] fw_data = 8'h00;
  logic       fw_ready;
  logic       init_done;

  logic [7:0] fw_bytes [FW_N];
  int cyc = 0;
  int errors = 0;
  int checks = 0;

  sensor_boot_seq #(
    .FW_LEN(FW_N), .RESET_CYC(RST_W), .FRAME_CYC(FRM_W),
    .GAP_CYC(GAP_W), .POST_CYC(PST_W)
  ) u_sensor_boot_seq (
    .clk(clk), .rst(rst), .start(start),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr), .acc_data(acc_data),
    .acc_ready(acc_ready), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .fw_valid(fw_valid), .fw_data(fw_data), .fw_ready(fw_ready), .init_done(init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i == 0) return "R2";
    if (i <= 5) return "R3";
    if (i <= 8) return "R4";
    if (i == 9) return "R5";
    if (i <= 14) return "R6";
    return "R8";
  endfunction

  // Plays the link engine: walks the expected table once per boot run.
  task automatic walk(input logic [7:0] light_rd);
    for (int i = 0; i < N_ENT; i++) begin
      logic [2:0] eop;
      logic [7:0] eaddr;
      logic [7:0] edata;
      int egap;
      int dcyc;
      eop   = SCRIPT[i][26:24];
      eaddr = SCRIPT[i][23:16];
      edata = SCRIPT[i][15:8];
      egap  = int'(SCRIPT[i][7:0]);
      if (eop == 3'd3) edata = fw_bytes[i-10];
      if (i == N_ENT-1) edata = light_rd & 8'hF0;
      while (!acc_valid) @(negedge clk);
      check(acc_op == eop && acc_addr == eaddr && acc_data == edata, tag_of(i),
            $sformatf("request %0d", i), {acc_op, acc_addr, acc_data}, {eop, eaddr, edata});
      if (i == 3) begin
        repeat (4) @(negedge clk);
        check(acc_valid && acc_addr == eaddr && acc_op == eop, "R11", "unaccepted request held",
              {acc_valid, acc_addr}, {1'b1, eaddr});
      end
      acc_ready = 1'b1;
      @(negedge clk);
      acc_ready = 1'b0;
      repeat (LAT-1) @(negedge clk);
      acc_rdata = (eop == 3'd1 && eaddr == 8'h20) ? light_rd : 8'hE7;
      acc_done  = 1'b1;
      dcyc      = cyc;
      @(negedge clk);
      acc_done  = 1'b0;
      if (i == N_ENT-1) begin
        check(init_done && !acc_valid, "R9", "done after final write", init_done, 1);
      end else begin
        while (!(acc_valid || fw_ready)) @(negedge clk);
        check(cyc - dcyc - 1 == egap, tag_of(i), $sformatf("gap after %0d", i),
              cyc - dcyc - 1, egap);
      end
    end
  endtask

  task automatic feed(input bit do_stall);
    for (int k = 0; k < FW_N; k++) begin
      while (!fw_ready) @(negedge clk);
      if (do_stall && k == 2) begin
        for (int s = 0; s < STALL; s++) begin
          start = (s == 5);
          @(negedge clk);
          check(!acc_valid && fw_ready && !init_done, (s == 6) ? "R10" : "R7",
                "stalled stream, no request", {acc_valid, fw_ready}, 2'b01);
        end
        start = 1'b0;
      end
      fw_valid = 1'b1;
      fw_data  = fw_bytes[k];
      @(negedge clk);
      fw_valid = 1'b0;
      fw_data  = 8'h00;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(!acc_valid, "R1", "acc_valid idle", acc_valid, 0);
    check(!fw_ready, "R1", "fw_ready idle", fw_ready, 0);
    check(!init_done, "R1", "init_done idle", init_done, 0);

    // Run 1: stream stalls before its third byte, busy start pulse.
    fw_bytes = '{8'h3C, 8'hA5, 8'h00, 8'hFF};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      walk(8'h7B);
      feed(1'b1);
    join
    repeat (10) @(negedge clk);
    check(init_done && !acc_valid && !fw_ready, "R9", "done held while idle",
          {init_done, acc_valid, fw_ready}, 3'b100);

    // Run 2: restart from the finished state.
    fw_bytes = '{8'h11, 8'h80, 8'h7F, 8'hC3};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!init_done && acc_valid, "R10", "restart clears done",
          {init_done, acc_valid}, 2'b01);
    fork
      walk(8'hC5);
      feed(1'b0);
    join
    repeat (5) @(negedge clk);
    check(init_done, "R9", "done after second run", init_done, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule